// File: doc/BRIEF.md
# Serial Memory Bus Slave

This block is the slave side of a two-wire serial bus, built in the style of a small serial EEPROM. It samples the bus clock and data lines on the core clock and recognises START and STOP conditions. It decodes an address byte and a word address, then serves byte writes, page writes and reads. The read forms are current-address, random (a dummy write followed by a repeated START) and sequential. The only pad-facing output is an open-drain enable for the data line.

Written bytes are gathered in a 16-entry page buffer. At a valid STOP the buffer is drained to the storage behind the block over a valid/ready write stream. The commit also starts a busy timer of a set number of clock cycles. The block ignores the bus while the timer runs or the buffer drains, so a master can poll for the end of a write by sending the address byte until it is acknowledged. Reads and write-protection checks use a plain combinational access port: the block presents a sector and an address, and the storage returns the byte and a reject flag.

Top module: `serial_mem_slave`

## Requirements
- R1: The address byte is decoded as follows: bits 7:4 must be 1010, bits 3:2 must equal `dev_sel[1:0]`, bit 1 selects the sector (0 = array, 1 = register space) and bit 0 selects read (1) or write (0). A matching byte is acknowledged. A mismatching byte is not acknowledged, and the slave then leaves SDA alone until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. In a write, the word-address byte and every accepted data byte are acknowledged. A single-byte write is committed as one write beat carrying the byte, its address and its sector.
- R3: A random read sends the address byte (write), the word address, a repeated START and the address byte (read). It returns the byte stored at that word address in the selected sector. The two sectors are separate address spaces.
- R4: In a write, the low 4 bits of the address count up and wrap from 15 to 0, and the upper bits stay fixed. For example, 12 bytes written from offset 10 land at offsets 10 to 15 and then 0 to 5.
- R5: A commit starts a busy interval of `BUSY_CYCLES` clock cycles. During it the address byte is not acknowledged. After it ends, the address byte is acknowledged again.
- R6: A write is committed only if the STOP arrives on a byte boundary after at least one data byte and its acknowledge have completed. A STOP in the middle of a byte, or a STOP after the word address alone, commits nothing and starts no busy interval.
- R7: A data byte whose location `acc_reject` flags is not acknowledged. The whole write is then dropped, including bytes accepted earlier in it, and no busy interval follows.
- R8: In a read, the slave keeps sending bytes from consecutive addresses while the master acknowledges each one. It stops sending and releases SDA after a byte the master does not acknowledge.
- R9: A current-address read returns the byte at one past the last address written or read.
- R10: A write to the register sector whose word address equals `WEN_ADDR` (default 0x00) is committed without the busy timer. The slave answers its address again as soon as the buffer has drained. Register writes to any other address do start the timer.
- R11: Write beats leave in ascending offset order within the page. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_sector` and `wr_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_sel | input | 2 | Strapped select bits compared with address-byte bits 3:2 |
| acc_sector | output | 1 | Sector of the current address pointer (0 array, 1 registers) |
| acc_addr | output | AW | Current address pointer |
| acc_rdata | input | 8 | Byte stored at acc_sector/acc_addr, combinational |
| acc_reject | input | 1 | acc_sector/acc_addr may not be written, combinational |
| wr_valid | output | 1 | Write beat available |
| wr_ready | input | 1 | Storage accepts the beat |
| wr_sector | output | 1 | Sector of the write beat |
| wr_addr | output | AW | Address of the write beat |
| wr_data | output | 8 | Data of the write beat |

## Verification
The bench writes 12 bytes from offset 10 of a page. A pointer that carried into the page bits would corrupt the neighbouring page and leave offset 0 unchanged. It polls straight after a commit and again after the timer: a slave that answered while busy, or never answered again, fails at one of the two polls. It ends writes with a STOP inside a byte and with a STOP after only the word address; a design that committed either would emit beats and refuse the next poll. It also holds `wr_ready` low to catch beats that move or get lost under back-pressure, and covers the register write that must skip the timer.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_WADDR,
    S_WDATA,
    S_RDATA
  } bus_st_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_n, sda_n;

  assign scl_n = scl_ff[STAGES-1];
  assign sda_n = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_n;
      sda_q  <= sda_n;
    end
  end

  assign sda_s     = sda_n;
  assign scl_rise  = scl_n & ~scl_q;
  assign scl_fall  = ~scl_n & scl_q;
  assign start_det = scl_n & scl_q & sda_q & ~sda_n;
  assign stop_det  = scl_n & scl_q & ~sda_q & sda_n;
endmodule

// File: rtl/i2cs_busy_timer.sv
module i2cs_busy_timer #(
  parameter int CYCLES = 1000000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  assert_load_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
endmodule

// File: rtl/i2cs_page_buf.sv
module i2cs_page_buf #(
  parameter int OW = 4,
  parameter int TW = 5,
  localparam int DEPTH = 1 << OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [OW-1:0] woff,
  input  logic [7:0]    wdata,
  input  logic          clr,
  input  logic          commit,
  input  logic [TW-1:0] commit_tag,
  output logic          flushing,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [TW-1:0] wr_tag,
  output logic [OW-1:0] wr_off,
  output logic [7:0]    wr_data
);
  logic [7:0]       mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [OW-1:0]    idx_q;
  logic [TW-1:0]    tag_q;
  logic             advance;

  assign advance = flushing && (!vld_q[idx_q] || wr_ready);

  always_ff @(posedge clk) begin
    if (wen && !flushing) mem_q[woff] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      idx_q    <= '0;
      tag_q    <= '0;
      flushing <= 1'b0;
    end else if (flushing) begin
      if (advance) begin
        vld_q[idx_q] <= 1'b0;
        idx_q        <= idx_q + 1'b1;
        if (idx_q == OW'(DEPTH - 1)) flushing <= 1'b0;
      end
    end else if (commit) begin
      flushing <= 1'b1;
      idx_q    <= '0;
      tag_q    <= commit_tag;
    end else if (clr) begin
      vld_q <= '0;
    end else if (wen) begin
      vld_q[woff] <= 1'b1;
    end
  end

  assign wr_valid = flushing && vld_q[idx_q];
  assign wr_data  = mem_q[idx_q];
  assign wr_off   = idx_q;
  assign wr_tag   = tag_q;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_off) && $stable(wr_tag)));
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import i2cs_pkg::*;
#(
  parameter int             AW          = 8,
  parameter int             OW          = 4,
  parameter int             BUSY_CYCLES = 1000000,
  parameter logic [AW-1:0]  WEN_ADDR    = '0,
  localparam int            TW          = AW - OW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [1:0]    dev_sel,
  output logic          acc_sector,
  output logic [AW-1:0] acc_addr,
  input  logic [7:0]    acc_rdata,
  input  logic          acc_reject,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic          wr_sector,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic tmr_busy, flushing, busy;

  bus_st_e       st_q;
  logic [3:0]    bit_cnt_q;
  logic          ack_ph_q;
  logic [7:0]    shreg_q, tx_sh_q;
  logic          sda_oe_q, sector_q, rw_q, have_data_q, mack_q, wen_txn_q;
  logic [AW-1:0] ptr_q;

  logic byte_done, ack_end, addr_ok, stop_ok;
  logic buf_wen, buf_clr, tmr_load;
  logic [TW-1:0] wr_tag;
  logic [OW-1:0] wr_off;

  i2cs_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign busy      = tmr_busy | flushing;
  assign byte_done = scl_fall && (st_q != S_IDLE) && !ack_ph_q && (bit_cnt_q == 4'd8);
  assign ack_end   = scl_fall && (st_q != S_IDLE) && ack_ph_q;
  assign addr_ok   = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[3:2] == dev_sel);
  assign stop_ok   = stop_det && (st_q == S_WDATA) && have_data_q && !ack_ph_q
                     && (bit_cnt_q <= 4'd1);
  assign buf_wen   = ack_end && (st_q == S_WDATA);
  assign buf_clr   = (start_det || stop_det) && !busy && !stop_ok;
  assign tmr_load  = stop_ok && !wen_txn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      bit_cnt_q   <= '0;
      ack_ph_q    <= 1'b0;
      shreg_q     <= '0;
      tx_sh_q     <= '0;
      sda_oe_q    <= 1'b0;
      sector_q    <= 1'b0;
      rw_q        <= 1'b0;
      ptr_q       <= '0;
      have_data_q <= 1'b0;
      mack_q      <= 1'b0;
      wen_txn_q   <= 1'b0;
    end else if (start_det) begin
      if (!busy) st_q <= S_ADDR;
      bit_cnt_q   <= '0;
      ack_ph_q    <= 1'b0;
      sda_oe_q    <= 1'b0;
      have_data_q <= 1'b0;
    end else if (stop_det) begin
      st_q        <= S_IDLE;
      bit_cnt_q   <= '0;
      ack_ph_q    <= 1'b0;
      sda_oe_q    <= 1'b0;
      have_data_q <= 1'b0;
    end else if (st_q != S_IDLE) begin
      if (scl_rise) begin
        if (!ack_ph_q && bit_cnt_q != 4'd8) begin
          shreg_q   <= {shreg_q[6:0], sda_s};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (ack_ph_q) begin
          mack_q <= !sda_s;
        end
      end
      if (byte_done) begin
        case (st_q)
          S_ADDR: begin
            if (addr_ok) begin
              ack_ph_q <= 1'b1;
              sda_oe_q <= 1'b1;
              sector_q <= shreg_q[1];
              rw_q     <= shreg_q[0];
            end else begin
              st_q     <= S_IDLE;
              sda_oe_q <= 1'b0;
            end
          end
          S_WADDR: begin
            ack_ph_q  <= 1'b1;
            sda_oe_q  <= 1'b1;
            ptr_q     <= shreg_q[AW-1:0];
            wen_txn_q <= sector_q && (shreg_q[AW-1:0] == WEN_ADDR);
          end
          S_WDATA: begin
            if (!acc_reject) begin
              ack_ph_q <= 1'b1;
              sda_oe_q <= 1'b1;
            end else begin
              st_q     <= S_IDLE;
              sda_oe_q <= 1'b0;
            end
          end
          S_RDATA: begin
            ack_ph_q <= 1'b1;
            sda_oe_q <= 1'b0;
            ptr_q    <= ptr_q + AW'(1);
          end
          default: st_q <= S_IDLE;
        endcase
      end else if (ack_end) begin
        ack_ph_q  <= 1'b0;
        bit_cnt_q <= '0;
        sda_oe_q  <= 1'b0;
        case (st_q)
          S_ADDR: begin
            if (rw_q) begin
              st_q     <= S_RDATA;
              tx_sh_q  <= acc_rdata;
              sda_oe_q <= !acc_rdata[7];
            end else begin
              st_q <= S_WADDR;
            end
          end
          S_WADDR: st_q <= S_WDATA;
          S_WDATA: begin
            ptr_q       <= {ptr_q[AW-1:OW], ptr_q[OW-1:0] + OW'(1)};
            have_data_q <= 1'b1;
          end
          S_RDATA: begin
            if (mack_q) begin
              tx_sh_q  <= acc_rdata;
              sda_oe_q <= !acc_rdata[7];
            end else begin
              st_q <= S_IDLE;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end else if (scl_fall && st_q == S_RDATA && bit_cnt_q != 4'd0) begin
        tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
        sda_oe_q <= !tx_sh_q[6];
      end
    end
  end

  i2cs_page_buf #(.OW(OW), .TW(TW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wen(buf_wen), .woff(ptr_q[OW-1:0]), .wdata(shreg_q),
    .clr(buf_clr), .commit(stop_ok), .commit_tag({sector_q, ptr_q[AW-1:OW]}),
    .flushing(flushing),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_tag(wr_tag), .wr_off(wr_off), .wr_data(wr_data)
  );

  i2cs_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .busy(tmr_busy)
  );

  assign sda_oe     = sda_oe_q;
  assign acc_sector = sector_q;
  assign acc_addr   = ptr_q;
  assign wr_sector  = wr_tag[TW-1];
  assign wr_addr    = {wr_tag[TW-2:0], wr_off};

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> !sda_oe_q);

  assert_busy_from_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_busy) |-> $past(stop_det));

  assert_busy_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe_q);

  assert_page_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[AW-1:OW] == ptr_q[AW-1:OW]));
endmodule

// File: tb/test_serial_mem_slave.sv
module test_serial_mem_slave;
  localparam int BUSY = 3000;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, rdy = 1'b1;
  logic sda_oe, acc_sector, acc_reject, wr_valid, wr_sector;
  logic [7:0] acc_addr, acc_rdata, wr_addr, wr_data;
  logic sda_line;
  logic [7:0] mem_arr [256];
  logic [7:0] mem_reg [256];
  logic [7:0] log_a [32];
  logic [7:0] log_d [32];
  logic       log_s [32];
  int beats = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign sda_line   = sda_m & ~sda_oe;
  assign acc_rdata  = acc_sector ? mem_reg[acc_addr] : mem_arr[acc_addr];
  assign acc_reject = !acc_sector && (acc_addr[7:4] == 4'hF || acc_addr == 8'h9C);

  serial_mem_slave #(.BUSY_CYCLES(BUSY)) i_serial_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_sel(2'b10), .acc_sector(acc_sector), .acc_addr(acc_addr),
    .acc_rdata(acc_rdata), .acc_reject(acc_reject),
    .wr_valid(wr_valid), .wr_ready(rdy), .wr_sector(wr_sector),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        mem_arr[i] <= 8'(i) ^ 8'h5A;
        mem_reg[i] <= 8'h00;
      end
    end else if (wr_valid && rdy) begin
      if (wr_sector) mem_reg[wr_addr] <= wr_data;
      else mem_arr[wr_addr] <= wr_data;
      log_a[beats % 32] <= wr_addr;
      log_d[beats % 32] <= wr_data;
      log_s[beats % 32] <= wr_sector;
      beats <= beats + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic sec, input logic rd);
    return {4'b1010, 2'b10, sec, rd};
  endfunction

  task automatic b_start();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask

  task automatic b_stop();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); q();
  endtask

  task automatic b_bit(input logic b);
    sda_m = b; q(); scl_m = 1; q(); q(); scl_m = 0; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) b_bit(b[i]);
    sda_m = 1; q(); scl_m = 1; q(); ack = !sda_line; q(); scl_m = 0; q();
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; q(); scl_m = 1; q(); d[i] = sda_line; q(); scl_m = 0; q();
    end
    sda_m = !mack; q(); scl_m = 1; q(); q(); scl_m = 0; q();
    sda_m = 1;
  endtask

  task automatic rand_read(input logic sec, input logic [7:0] a, output logic [7:0] d);
    logic ak;
    b_start(); wbyte(dev(sec, 0), ak); wbyte(a, ak);
    b_start(); wbyte(dev(sec, 1), ak); rbyte(0, d); b_stop();
  endtask

  task automatic t_reset();
    chk("R1 sda idle after reset", sda_oe, 0);
    chk("R11 no beat after reset", wr_valid, 0);
  endtask

  task automatic t_mismatch();
    logic ak;
    b_start(); wbyte(8'b1010_01_0_0, ak); b_stop();
    chk("R1 wrong select nack", ak, 0);
    b_start(); wbyte(8'b1011_10_0_0, ak); b_stop();
    chk("R1 wrong type nack", ak, 0);
    chk("R1 sda released", sda_oe, 0);
  endtask

  task automatic t_byte_write();
    logic ak1, ak2, ak3; logic [7:0] d; int b0;
    b0 = beats;
    b_start(); wbyte(dev(0, 0), ak1); wbyte(8'h12, ak2); wbyte(8'hC3, ak3); b_stop();
    cyc(60);
    chk("R1 address ack", ak1, 1);
    chk("R2 word address ack", ak2, 1);
    chk("R2 data ack", ak3, 1);
    chk("R2 one beat", beats - b0, 1);
    chk("R2 beat address", log_a[b0 % 32], 8'h12);
    chk("R2 beat data", log_d[b0 % 32], 8'hC3);
    chk("R2 beat sector", log_s[b0 % 32], 0);
    cyc(BUSY);
    rand_read(0, 8'h12, d);
    chk("R3 random read", d, 8'hC3);
  endtask

  task automatic t_page_wrap();
    logic ak; logic [7:0] d; int b0;
    b0 = beats;
    b_start(); wbyte(dev(0, 0), ak); wbyte(8'h2A, ak);
    for (int k = 0; k < 12; k++) wbyte(8'hA0 + 8'(k), ak);
    b_stop();
    cyc(60);
    chk("R4 twelve beats", beats - b0, 12);
    chk("R11 ascending first beat", log_a[b0 % 32], 8'h20);
    chk("R11 first beat data", log_d[b0 % 32], 8'hA6);
    cyc(BUSY);
    b_start(); wbyte(dev(0, 1), ak); rbyte(0, d); b_stop();
    chk("R9 current after wrapped write", d, 8'h26 ^ 8'h5A);
    rand_read(0, 8'h20, d); chk("R4 offset 0", d, 8'hA6);
    rand_read(0, 8'h25, d); chk("R4 offset 5", d, 8'hAB);
    rand_read(0, 8'h2F, d); chk("R4 offset 15", d, 8'hA5);
    rand_read(0, 8'h30, d); chk("R4 next page untouched", d, 8'h30 ^ 8'h5A);
  endtask

  task automatic t_busy_poll();
    logic ak; logic [7:0] d;
    b_start(); wbyte(dev(0, 0), ak); wbyte(8'h50, ak); wbyte(8'h11, ak); b_stop();
    b_start(); wbyte(dev(0, 1), ak); b_stop();
    chk("R5 nack while busy", ak, 0);
    cyc(BUSY);
    b_start(); wbyte(dev(0, 1), ak); rbyte(0, d); b_stop();
    chk("R5 ack after busy", ak, 1);
    chk("R9 current after write", d, 8'h51 ^ 8'h5A);
  endtask

  task automatic t_abort();
    logic ak; logic [7:0] d; int b0;
    b0 = beats;
    b_start(); wbyte(dev(0, 0), ak); wbyte(8'h60, ak); wbyte(8'h77, ak);
    b_bit(1); b_bit(0); b_bit(1); b_stop();
    cyc(40);
    chk("R6 mid-byte stop no beat", beats - b0, 0);
    b_start(); wbyte(dev(0, 1), ak); rbyte(0, d); b_stop();
    chk("R6 no busy after abort", ak, 1);
    rand_read(0, 8'h60, d);
    chk("R6 location unchanged", d, 8'h60 ^ 8'h5A);
    b_start(); wbyte(dev(0, 0), ak); wbyte(8'h70, ak); b_stop();
    cyc(40);
    chk("R6 address-only no beat", beats - b0, 0);
    b_start(); wbyte(dev(0, 1), ak); rbyte(0, d); b_stop();
    chk("R6 address-only no busy", ak, 1);
    chk("R9 pointer from word address", d, 8'h70 ^ 8'h5A);
  endtask

  task automatic t_protect();
    logic ak, a1, a2, a3; logic [7:0] d; int b0;
    b0 = beats;
    b_start(); wbyte(dev(0, 0), ak); wbyte(8'h9A, ak);
    wbyte(8'h01, a1); wbyte(8'h02, a2); wbyte(8'h03, a3); b_stop();
    cyc(40);
    chk("R7 open byte ack", a1 & a2, 1);
    chk("R7 protected byte nack", a3, 0);
    chk("R7 nothing committed", beats - b0, 0);
    b_start(); wbyte(dev(0, 1), ak); rbyte(0, d); b_stop();
    chk("R7 no busy", ak, 1);
    rand_read(0, 8'h9A, d);
    chk("R7 earlier byte dropped", d, 8'h9A ^ 8'h5A);
  endtask

  task automatic t_seq_read();
    logic ak; logic [7:0] d0, d1, d2, d3;
    b_start(); wbyte(dev(0, 0), ak); wbyte(8'h2E, ak);
    b_start(); wbyte(dev(0, 1), ak);
    rbyte(1, d0); rbyte(1, d1); rbyte(1, d2); rbyte(0, d3);
    chk("R8 released after nack", sda_oe, 0);
    b_stop();
    chk("R8 byte 0", d0, 8'hA4);
    chk("R8 byte 1", d1, 8'hA5);
    chk("R8 byte 2", d2, 8'h30 ^ 8'h5A);
    chk("R8 byte 3", d3, 8'h31 ^ 8'h5A);
    b_start(); wbyte(dev(0, 1), ak); rbyte(0, d0); b_stop();
    chk("R9 current after sequential read", d0, 8'h32 ^ 8'h5A);
  endtask

  task automatic t_wen();
    logic ak; logic [7:0] d;
    b_start(); wbyte(dev(1, 0), ak); wbyte(8'h00, ak); wbyte(8'h80, ak); b_stop();
    cyc(40);
    b_start(); wbyte(dev(1, 1), ak); rbyte(0, d); b_stop();
    chk("R10 enable write no busy", ak, 1);
    rand_read(1, 8'h00, d);
    chk("R10 register written", d, 8'h80);
    rand_read(0, 8'h00, d);
    chk("R3 array sector separate", d, 8'h5A);
    b_start(); wbyte(dev(1, 0), ak); wbyte(8'h02, ak); wbyte(8'h0C, ak); b_stop();
    b_start(); wbyte(dev(1, 1), ak); b_stop();
    chk("R10 other register busy", ak, 0);
    cyc(BUSY);
  endtask

  task automatic t_backpressure();
    logic ak; int b0; logic [7:0] a0, d0;
    b0 = beats;
    rdy = 0;
    b_start(); wbyte(dev(0, 0), ak); wbyte(8'h44, ak);
    wbyte(8'h55, ak); wbyte(8'h66, ak); b_stop();
    cyc(10);
    a0 = wr_addr; d0 = wr_data;
    chk("R11 valid while stalled", wr_valid, 1);
    cyc(30);
    chk("R11 valid held", wr_valid, 1);
    chk("R11 address held", wr_addr, a0);
    chk("R11 data held", wr_data, d0);
    chk("R11 no beat taken", beats - b0, 0);
    rdy = 1;
    cyc(40);
    chk("R11 both beats", beats - b0, 2);
    chk("R11 order first", log_a[b0 % 32], 8'h44);
    chk("R11 order second", log_a[(b0 + 1) % 32], 8'h45);
    chk("R11 second data", log_d[(b0 + 1) % 32], 8'h66);
    cyc(BUSY);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    cyc(5);
    rst_n = 1;
    cyc(5);
    t_reset();
    t_mismatch();
    t_byte_write();
    t_page_wrap();
    t_busy_poll();
    t_abort();
    t_protect();
    t_seq_read();
    t_wen();
    t_backpressure();
    finish_run();
  end
endmodule